// File: doc/BRIEF.md
# Snooping MESI data cache controller

A private, set-associative, write-back data cache controller for one core of a small multiprocessor. The core issues word loads and stores and holds each request until it is acknowledged. Loads and stores that hit complete in the cycle they are presented. A miss first selects a victim way. If that victim is dirty, it is written back. The controller then fetches the whole line over a single-beat line port toward the next level. Store misses allocate the line before the store is merged into it.

Coherence with the other cores uses a four-state invalidation protocol: Modified, Exclusive, Shared and Invalid. Peer requests arrive on a snoop port and may ask to read a line, to read it for ownership, or to invalidate it. The controller answers each one in the same cycle with a hit flag, a dirty flag and the line contents. A snoop uses the tag and data arrays for one whole cycle. In that cycle any core access is held off and no request is issued toward the next level.

Capacity, line size, word width and associativity are parameters. The defaults are a 32 KB cache with 2 ways and 32-byte lines. Replacement keeps one least-recently-used bit per set.

Top module: `cc_mesi_dcache`

## Requirements
- R1: After reset every line is Invalid and no LRU history is kept: `core_stall` and `mem_req` are low while idle, and a snoop to any address reports `snp_hit`=0.
- R2: A load or store that hits a line it may use raises `core_ack` in the same cycle. It issues nothing on the memory port, and a load returns the word at `core_addr`. Core addresses are aligned to DATA_W/8 bytes.
- R3: A load miss issues `mem_op`=0 (read) for the line-aligned address and then completes on the third cycle of the request. The line fills in Exclusive when `mem_shared` is low during the fill and in Shared otherwise.
- R4: A store miss issues `mem_op`=1 (read for ownership) and then merges the store word into the fetched line. The line ends up Modified.
- R5: A store that hits a Shared line first issues `mem_op`=3 (upgrade) for that line. The line then becomes Modified and the store completes on the third cycle.
- R6: A store that hits an Exclusive or Modified line completes in one cycle with no memory-port transaction, and the line becomes Modified.
- R7: A snoop read (`snp_op`=0) that hits raises `snp_hit` and leaves the line Shared. If the line was Modified, it also raises `snp_dirty` and returns the line on `snp_data`. Snoop addresses are line-aligned.
- R8: A snoop read-for-ownership (`snp_op`=1) or invalidate (`snp_op`=2) that hits moves the line to Invalid, so the next core access to it misses. Read-for-ownership of a Modified line also raises `snp_dirty` and returns the data.
- R9: In a cycle with `snp_valid` high, a core request gets `core_stall`=1 and `core_ack`=0, and `mem_req` stays low. The request completes once the snoop has gone.
- R10: A miss whose victim is Modified first issues `mem_op`=2 (writeback) with the victim's line address and data, and only then the fill. The access completes on the fourth cycle.
- R11: The victim is way 0 if it is Invalid, else way 1 if it is Invalid, else the way named by the set's LRU bit. Each hit or fill points that bit at the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core access request, held until acknowledged |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Byte address of the word |
| core_wdata | input | DATA_W | Store data |
| core_rdata | output | DATA_W | Load data, valid with core_ack |
| core_ack | output | 1 | Access completes this cycle |
| core_stall | output | 1 | Request pending and not completing |
| snp_valid | input | 1 | Peer snoop present this cycle |
| snp_op | input | 2 | 0 read, 1 read for ownership, 2 invalidate |
| snp_addr | input | ADDR_W | Line-aligned snoop address |
| snp_hit | output | 1 | Snooped line held here |
| snp_dirty | output | 1 | Snooped line was Modified; data supplied |
| snp_data | output | LINE_W | Contents of the snooped line |
| mem_req | output | 1 | Next-level request |
| mem_op | output | 2 | 0 read, 1 read for ownership, 2 writeback, 3 upgrade |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_wdata | output | LINE_W | Writeback line |
| mem_ack | input | 1 | Request accepted/completed this cycle |
| mem_rdata | input | LINE_W | Fill line, valid with mem_ack |
| mem_shared | input | 1 | Another cache holds the line being filled |

## Verification
The two functions that can fall in the same cycle are a peer snoop and a core access, both of which need the arrays. The bench drives `snp_valid` on the same clock phase as a core load that would otherwise hit. In that cycle it expects `core_stall`=1, `core_ack`=0 and a quiet memory port. It then expects the load to complete with the correct word in the cycle after the snoop is removed. Snoops also interleave with fills and upgrades across all sets of a small four-set configuration. The resulting state changes are judged only through later hit, miss and upgrade traffic.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef enum logic [1:0] {
      ST_I = 2'd0,
      ST_S = 2'd1,
      ST_E = 2'd2,
      ST_M = 2'd3
   } mesi_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_WB   = 2'd1,
      FS_FILL = 2'd2,
      FS_UPG  = 2'd3
   } fsm_t;

   localparam logic [1:0] MOP_READ = 2'd0;
   localparam logic [1:0] MOP_RDX  = 2'd1;
   localparam logic [1:0] MOP_WB   = 2'd2;
   localparam logic [1:0] MOP_UPG  = 2'd3;

   localparam logic [1:0] SOP_RD   = 2'd0;
   localparam logic [1:0] SOP_RDX  = 2'd1;
   localparam logic [1:0] SOP_INV  = 2'd2;

endpackage

// File: rtl/cc_lookup.sv
module cc_lookup #(
   parameter int unsigned WAYS  = 2,
   parameter int unsigned TAG_W = 8,
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags,
   input  logic [WAYS-1:0]             valid,
   input  logic [TAG_W-1:0]            tag,
   output logic                        hit,
   output logic [WAY_W-1:0]            way
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid[w] && (tags[w] == tag);
   end

   always_comb begin
      hit = |match;
      way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) way = WAY_W'(w);
      end
   end

   AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match)); // R11

endmodule

// File: rtl/cc_victim.sv
module cc_victim #(
   parameter int unsigned WAYS = 2,
   localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]  valid,
   input  logic             lru,
   output logic [WAY_W-1:0] way
);

   if (WAYS == 2) begin : g_two_way
      always_comb begin
         if (!valid[0])      way = WAY_W'(0);
         else if (!valid[1]) way = WAY_W'(1);
         else                way = WAY_W'(lru);
      end
   end else begin : g_bad_ways
      $error("cc_victim: single LRU bit supports exactly two ways");
   end

endmodule

// File: rtl/cc_mesi_dcache.sv
module cc_mesi_dcache
   import cc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CACHE_BYTES = 32768,
   parameter int unsigned LINE_BYTES  = 32,
   parameter int unsigned WAYS        = 2,
   localparam int unsigned LINE_W     = LINE_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [DATA_W-1:0] core_wdata,
   output logic [DATA_W-1:0] core_rdata,
   output logic              core_ack,
   output logic              core_stall,
   input  logic              snp_valid,
   input  logic [1:0]        snp_op,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_hit,
   output logic              snp_dirty,
   output logic [LINE_W-1:0] snp_data,
   output logic              mem_req,
   output logic [1:0]        mem_op,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata,
   input  logic              mem_shared
);

   localparam int unsigned SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W  = $clog2(SETS);
   localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int unsigned BOFF_W = $clog2(DATA_W / 8);
   localparam int unsigned WORDS  = LINE_W / DATA_W;
   localparam int unsigned WSEL_W = $clog2(WORDS);
   localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

   // elaboration-time parameter checks
   if (WAYS != 2) begin : g_chk_ways
      $error("cc_mesi_dcache: WAYS must be 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_chk_sets
      $error("cc_mesi_dcache: set count must be a power of two >= 2");
   end
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_data
      $error("cc_mesi_dcache: DATA_W must be a power of two >= 16");
   end
   if (WORDS < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_chk_line
      $error("cc_mesi_dcache: line must be a power of two holding >= 2 words");
   end

   // arrays
   logic [TAG_W-1:0]  tag_q [SETS][WAYS];
   logic [LINE_W-1:0] dat_q [SETS][WAYS];
   mesi_t             st_q  [SETS][WAYS];
   logic [SETS-1:0]   lru_q;

   fsm_t              fsm_q;
   logic [WAY_W-1:0]  vic_q;

   // address fields
   logic [TAG_W-1:0]  c_tag, s_tag;
   logic [IDX_W-1:0]  c_idx, s_idx;
   logic [WSEL_W-1:0] c_wsel;

   assign c_tag  = core_addr[ADDR_W-1 -: TAG_W];
   assign c_idx  = core_addr[OFF_W +: IDX_W];
   assign c_wsel = core_addr[BOFF_W +: WSEL_W];
   assign s_tag  = snp_addr[ADDR_W-1 -: TAG_W];
   assign s_idx  = snp_addr[OFF_W +: IDX_W];

   // per-way slices of the addressed sets
   logic [WAYS-1:0][TAG_W-1:0] c_tags, s_tags;
   logic [WAYS-1:0]            c_valid, s_valid;

   for (genvar w = 0; w < WAYS; w++) begin : g_slice
      assign c_tags[w]  = tag_q[c_idx][w];
      assign c_valid[w] = (st_q[c_idx][w] != ST_I);
      assign s_tags[w]  = tag_q[s_idx][w];
      assign s_valid[w] = (st_q[s_idx][w] != ST_I);
   end

   logic             c_hit, s_hit;
   logic [WAY_W-1:0] c_way, s_way, vic_way;

   cc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_core_look (
      .clk(clk), .rst_n(rst_n), .tags(c_tags), .valid(c_valid), .tag(c_tag),
      .hit(c_hit), .way(c_way));

   cc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_look (
      .clk(clk), .rst_n(rst_n), .tags(s_tags), .valid(s_valid), .tag(s_tag),
      .hit(s_hit), .way(s_way));

   cc_victim #(.WAYS(WAYS)) u_victim (
      .valid(c_valid), .lru(lru_q[c_idx]), .way(vic_way));

   mesi_t c_st, s_st, v_st;
   assign c_st = st_q[c_idx][c_way];
   assign s_st = st_q[s_idx][s_way];
   assign v_st = st_q[c_idx][vic_q];

   // core side
   assign core_ack   = core_req && !snp_valid && (fsm_q == FS_IDLE) && c_hit &&
                       !(core_we && c_st == ST_S);
   assign core_stall = core_req && !core_ack;
   assign core_rdata = dat_q[c_idx][c_way][c_wsel*DATA_W +: DATA_W];

   // snoop side: array is owned by the snoop for this cycle
   assign snp_hit   = snp_valid && s_hit;
   assign snp_dirty = snp_hit && (s_st == ST_M);
   assign snp_data  = dat_q[s_idx][s_way];

   // next-level port
   always_comb begin
      mem_req  = 1'b0;
      mem_op   = MOP_READ;
      mem_addr = {c_tag, c_idx, {OFF_W{1'b0}}};
      unique case (fsm_q)
         FS_WB: begin
            mem_req  = !snp_valid && (v_st == ST_M);
            mem_op   = MOP_WB;
            mem_addr = {tag_q[c_idx][vic_q], c_idx, {OFF_W{1'b0}}};
         end
         FS_FILL: begin
            mem_req = !snp_valid;
            mem_op  = core_we ? MOP_RDX : MOP_READ;
         end
         FS_UPG: begin
            mem_req = !snp_valid && c_hit && (c_st == ST_S);
            mem_op  = MOP_UPG;
         end
         default: ;
      endcase
   end
   assign mem_wdata = dat_q[c_idx][vic_q];

   logic wb_done, fill_done, upg_done;
   assign wb_done   = (fsm_q == FS_WB)   && mem_req && mem_ack;
   assign fill_done = (fsm_q == FS_FILL) && mem_req && mem_ack;
   assign upg_done  = (fsm_q == FS_UPG)  && mem_req && mem_ack;

   // miss sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q <= FS_IDLE;
         vic_q <= '0;
      end else begin
         unique case (fsm_q)
            FS_IDLE: begin
               if (core_req && !snp_valid) begin
                  if (!c_hit) begin
                     vic_q <= vic_way;
                     fsm_q <= (st_q[c_idx][vic_way] == ST_M) ? FS_WB : FS_FILL;
                  end else if (core_we && c_st == ST_S) begin
                     fsm_q <= FS_UPG;
                  end
               end
            end
            FS_WB: begin
               if (wb_done || (!snp_valid && v_st != ST_M)) fsm_q <= FS_FILL;
            end
            FS_FILL: begin
               if (fill_done) fsm_q <= FS_IDLE;
            end
            FS_UPG: begin
               if (upg_done || (!snp_valid && !(c_hit && c_st == ST_S)))
                  fsm_q <= FS_IDLE;
            end
            default: fsm_q <= FS_IDLE;
         endcase
      end
   end

   // line state and replacement history
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SETS; i++) begin
            for (int w = 0; w < WAYS; w++) st_q[i][w] <= ST_I;
         end
         lru_q <= '0;
      end else if (snp_valid) begin
         if (s_hit) begin
            unique case (snp_op)
               SOP_RD:           st_q[s_idx][s_way] <= ST_S;
               SOP_RDX, SOP_INV: st_q[s_idx][s_way] <= ST_I;
               default: ;
            endcase
         end
      end else if (fill_done) begin
         st_q[c_idx][vic_q] <= core_we ? ST_M : (mem_shared ? ST_S : ST_E);
         lru_q[c_idx]       <= !vic_q[0];
      end else if (wb_done) begin
         st_q[c_idx][vic_q] <= ST_I;
      end else if (upg_done) begin
         st_q[c_idx][c_way] <= ST_M;
      end else if (core_ack) begin
         lru_q[c_idx] <= !c_way[0];
         if (core_we) st_q[c_idx][c_way] <= ST_M;
      end
   end

   // tag and data storage
   always_ff @(posedge clk) begin
      if (fill_done) begin
         tag_q[c_idx][vic_q] <= c_tag;
         dat_q[c_idx][vic_q] <= mem_rdata;
      end else if (core_ack && core_we) begin
         dat_q[c_idx][c_way][c_wsel*DATA_W +: DATA_W] <= core_wdata;
      end
   end

   AST_SNOOP_STALLS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && core_req) |-> (core_stall && !core_ack)); // R9
   AST_SNOOP_QUIETS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> !mem_req); // R9
   AST_CLEAN_BEFORE_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_q == FS_FILL && mem_req) |-> (v_st != ST_M)); // R10
   AST_UPGRADE_FROM_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
      upg_done |=> (fsm_q == FS_IDLE)); // R5
   AST_CORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      core_req |-> (core_addr[BOFF_W-1:0] == '0)); // R2
   AST_SNOOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> (snp_addr[OFF_W-1:0] == '0)); // R7

endmodule

// File: tb/sim_cc_mesi_dcache.sv
`timescale 1ns/1ps
module sim_cc_mesi_dcache;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int LW = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          core_req = 0, core_we = 0;
   logic [AW-1:0] core_addr = '0;
   logic [DW-1:0] core_wdata = '0, core_rdata;
   logic          core_ack, core_stall;
   logic          snp_valid = 0;
   logic [1:0]    snp_op = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_hit, snp_dirty;
   logic [LW-1:0] snp_data;
   logic          mem_req, mem_ack, mem_shared = 0;
   logic [1:0]    mem_op;
   logic [AW-1:0] mem_addr;
   logic [LW-1:0] mem_wdata, mem_rdata = '0;

   cc_mesi_dcache #(.ADDR_W(AW), .DATA_W(DW), .CACHE_BYTES(256),
                    .LINE_BYTES(32), .WAYS(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_rdata(core_rdata), .core_ack(core_ack),
      .core_stall(core_stall),
      .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
      .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_data(snp_data),
      .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_shared(mem_shared));

   int nchk = 0, nerr = 0;

   // zero-wait next level with a writeback store
   logic [LW-1:0] wmem [int unsigned];
   int            nlog;
   logic [1:0]    lop   [4];
   logic [AW-1:0] laddr [4];
   logic [LW-1:0] ldata [4];

   assign mem_ack = mem_req;

   function automatic logic [31:0] addr_of(int t, int s, int w);
      return 32'((t << 7) | (s << 5) | (w << 2));
   endfunction
   function automatic logic [31:0] pat(logic [31:0] a);
      return a ^ 32'h5A00_0000;
   endfunction
   function automatic logic [31:0] wv(logic [31:0] a);
      return a ^ 32'hC300_0000;
   endfunction

   always @(negedge clk) begin
      #2;
      if (wmem.exists(mem_addr)) mem_rdata = wmem[mem_addr];
      else for (int k = 0; k < 8; k++) mem_rdata[k*32 +: 32] = pat(mem_addr + 32'(k*4));
   end

   always @(posedge clk) begin
      if (mem_req === 1'b1 && mem_ack === 1'b1) begin
         if (nlog < 4) begin
            lop[nlog] = mem_op; laddr[nlog] = mem_addr; ldata[nlog] = mem_wdata;
         end
         if (mem_op == 2'd2) wmem[mem_addr] = mem_wdata;
         nlog++;
      end
   end

   task automatic chk(input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int cyc);
      @(negedge clk);
      nlog = 0; core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
      cyc = 0; rd = '0;
      forever begin
         #1; cyc++;
         if (core_ack === 1'b1) begin rd = core_rdata; break; end
         if (cyc > 40) break;
         @(negedge clk);
      end
      @(posedge clk); #1; core_req = 0;
   endtask

   task automatic snoop(input logic [1:0] op, input logic [31:0] a,
                        output logic h, output logic d, output logic [LW-1:0] dt);
      @(negedge clk);
      snp_valid = 1; snp_op = op; snp_addr = a;
      #1; h = snp_hit; d = snp_dirty; dt = snp_data;
      @(posedge clk); #1; snp_valid = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL watchdog (all requirements) act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      int cyc;
      logic h, d;
      logic [LW-1:0] dt;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1: idle after reset, nothing cached
      @(negedge clk); #1;
      chk("R1 core_stall idle", LW'(core_stall), LW'(0));
      chk("R1 mem_req idle", LW'(mem_req), LW'(0));
      for (int s = 0; s < 4; s++) begin
         snoop(2'd0, addr_of(1, s, 0), h, d, dt);
         chk("R1 empty snoop hit", LW'(h), LW'(0));
      end

      // R3 exclusive fills, then R6 silent upgrade
      mem_shared = 0;
      for (int s = 0; s < 4; s++) begin
         access(0, addr_of(1, s, 0), 0, rd, cyc);
         chk("R3 read miss cycles", LW'(cyc), LW'(3));
         chk("R3 read miss txns", LW'(nlog), LW'(1));
         chk("R3 read miss op", LW'(lop[0]), LW'(0));
         chk("R3 read miss addr", LW'(laddr[0]), LW'(addr_of(1, s, 0)));
         chk("R3 read miss data", LW'(rd), LW'(pat(addr_of(1, s, 0))));
         access(1, addr_of(1, s, 1), wv(addr_of(1, s, 1)), rd, cyc);
         chk("R6 store on E cycles", LW'(cyc), LW'(1));
         chk("R6 store on E txns", LW'(nlog), LW'(0));
      end

      // R3 shared fills, R5 upgrade, R2 hits
      mem_shared = 1;
      for (int s = 0; s < 4; s++) begin
         access(0, addr_of(2, s, 0), 0, rd, cyc);
         chk("R11 fill into empty way txns", LW'(nlog), LW'(1));
         chk("R3 shared fill data", LW'(rd), LW'(pat(addr_of(2, s, 0))));
         access(1, addr_of(2, s, 2), wv(addr_of(2, s, 2)), rd, cyc);
         chk("R5 upgrade cycles", LW'(cyc), LW'(3));
         chk("R5 upgrade txns", LW'(nlog), LW'(1));
         chk("R5 upgrade op", LW'(lop[0]), LW'(3));
         chk("R5 upgrade addr", LW'(laddr[0]), LW'(addr_of(2, s, 0)));
         access(0, addr_of(2, s, 2), 0, rd, cyc);
         chk("R2 load hit cycles", LW'(cyc), LW'(1));
         chk("R2 load hit data", LW'(rd), LW'(wv(addr_of(2, s, 2))));
         access(0, addr_of(1, s, 1), 0, rd, cyc);
         chk("R2 load hit other way", LW'(rd), LW'(wv(addr_of(1, s, 1))));
         chk("R2 load hit txns", LW'(nlog), LW'(0));
      end

      // R7 snoop read of a Modified line
      snoop(2'd0, addr_of(1, 0, 0), h, d, dt);
      chk("R7 snoop hit", LW'(h), LW'(1));
      chk("R7 snoop dirty", LW'(d), LW'(1));
      chk("R7 snoop word0", LW'(dt[0 +: 32]), LW'(pat(addr_of(1, 0, 0))));
      chk("R7 snoop word1", LW'(dt[32 +: 32]), LW'(wv(addr_of(1, 0, 1))));
      access(1, addr_of(1, 0, 3), wv(addr_of(1, 0, 3)), rd, cyc);
      chk("R7 line now shared, op", LW'(lop[0]), LW'(3));
      chk("R7 line now shared, cycles", LW'(cyc), LW'(3));

      // R8 read-for-ownership and invalidate
      snoop(2'd1, addr_of(2, 1, 0), h, d, dt);
      chk("R8 rdx snoop dirty", LW'(d), LW'(1));
      chk("R8 rdx snoop word2", LW'(dt[64 +: 32]), LW'(wv(addr_of(2, 1, 2))));
      access(0, addr_of(2, 1, 0), 0, rd, cyc);
      chk("R8 miss after rdx cycles", LW'(cyc), LW'(3));
      chk("R8 miss after rdx op", LW'(lop[0]), LW'(0));
      snoop(2'd2, addr_of(2, 1, 0), h, d, dt);
      chk("R8 inv snoop hit", LW'(h), LW'(1));
      chk("R8 inv snoop clean", LW'(d), LW'(0));
      access(0, addr_of(2, 1, 0), 0, rd, cyc);
      chk("R8 miss after inv cycles", LW'(cyc), LW'(3));

      // R9 snoop and core access in the same cycle
      @(negedge clk);
      core_req = 1; core_we = 0; core_addr = addr_of(1, 2, 1);
      snp_valid = 1; snp_op = 2'd0; snp_addr = addr_of(0, 3, 0);
      #1;
      chk("R9 stall under snoop", LW'(core_stall), LW'(1));
      chk("R9 no ack under snoop", LW'(core_ack), LW'(0));
      chk("R9 no mem req under snoop", LW'(mem_req), LW'(0));
      @(posedge clk); #1 snp_valid = 0;
      @(negedge clk); #1;
      chk("R9 ack after snoop", LW'(core_ack), LW'(1));
      chk("R9 data after snoop", LW'(core_rdata), LW'(wv(addr_of(1, 2, 1))));
      @(posedge clk); #1 core_req = 0;

      // R10, R4, R11 dirty eviction in set 2
      access(1, addr_of(3, 2, 4), wv(addr_of(3, 2, 4)), rd, cyc);
      chk("R10 evict cycles", LW'(cyc), LW'(4));
      chk("R10 evict txns", LW'(nlog), LW'(2));
      chk("R10 writeback op first", LW'(lop[0]), LW'(2));
      chk("R11 LRU victim addr", LW'(laddr[0]), LW'(addr_of(2, 2, 0)));
      chk("R10 writeback word2", LW'(ldata[0][64 +: 32]), LW'(wv(addr_of(2, 2, 2))));
      chk("R10 writeback word0", LW'(ldata[0][0 +: 32]), LW'(pat(addr_of(2, 2, 0))));
      chk("R4 rdx op", LW'(lop[1]), LW'(1));
      chk("R4 rdx addr", LW'(laddr[1]), LW'(addr_of(3, 2, 0)));
      access(0, addr_of(3, 2, 4), 0, rd, cyc);
      chk("R4 merged store", LW'(rd), LW'(wv(addr_of(3, 2, 4))));
      access(0, addr_of(1, 2, 1), 0, rd, cyc);
      chk("R11 recent line kept", LW'(cyc), LW'(1));
      access(0, addr_of(2, 2, 2), 0, rd, cyc);
      chk("R10 second evict cycles", LW'(cyc), LW'(4));
      chk("R11 second victim addr", LW'(laddr[0]), LW'(addr_of(3, 2, 0)));
      chk("R10 second writeback word4", LW'(ldata[0][128 +: 32]), LW'(wv(addr_of(3, 2, 4))));
      chk("R10 written-back data returns", LW'(rd), LW'(wv(addr_of(2, 2, 2))));

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule